// File: doc/BRIEF.md
# Four-Phase Pipeline Stage Latch Controller

This block runs one stage of a four-phase, return-to-zero, bundled-data pipeline. A producer offers a word on the input channel by raising `in_req`, and the stage answers with `in_ack`. The stage then offers the word to a consumer by raising `out_req`, and the consumer answers with `out_ack`. The word sits in a level-sensitive data latch. The latch passes its input through while `latch_en` is low and holds its contents while `latch_en` is high. The controller orders the latch closing against both handshakes. The word is therefore captured before the producer is released, and it stays put until the consumer has acknowledged it.

The design is a clocked emulation of a speed-independent controller. On each clock edge it evaluates the set and reset conditions of every state-holding control signal and updates all of them together. A signal whose condition holds at an edge always fires on that edge, so an enabled transition can never be withdrawn. The parameter `MODE` picks one of two controllers. The coupled controller drives `latch_en`, `in_ack` and `out_req` from a single C-element state. The semi-decoupled controller adds an internal state bit. That bit lets the latch reopen as soon as the consumer acknowledges, without waiting for the producer.

Top module: `pl_stage`

## Requirements
- R1: While reset is asserted, and in the cycles after it is released with all inputs low, `in_ack`, `out_req` and `latch_en` are 0 and the latch is transparent.
- R2: While `latch_en` is 0, `out_data` equals `in_data`. While `latch_en` is 1, `out_data` keeps the value `in_data` had in the last cycle before `latch_en` rose, even if `in_data` changes.
- R3: `in_ack` rises only while `latch_en` is 1. In the semi-decoupled mode (`MODE`=1), `latch_en` was already 1 in the cycle before `in_ack` rises.
- R4: `in_ack` rises only at a clock edge where `in_req` is 1, and falls only at an edge where `in_req` is 0.
- R5: `out_req` rises only at an edge where `out_ack` is 0, and falls only at an edge where `out_ack` is 1. `latch_en` is 1 whenever `out_req` is 1, so `out_data` is stable for as long as `out_req` stays high.
- R6: In the coupled mode (`MODE`=0), `in_ack`, `latch_en` and `out_req` are always equal. `out_req` is set at an edge where `in_req`=1 and `out_ack`=0, cleared at an edge where `in_req`=0 and `out_ack`=1, and held otherwise.
- R7: In the semi-decoupled mode, `latch_en` is 0 two clock edges after an edge at which `out_req` and `out_ack` are both 1, whatever the level of `in_req`.
- R8: In both modes, `in_ack` does not fall for a word until `out_ack` has risen for that word.
- R9: Every word the producer offers reaches the consumer exactly once, in the order it was offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Evaluation clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_req | input | 1 | Producer request; the data is valid while it is high |
| in_data | input | WIDTH | Producer data |
| in_ack | output | 1 | Acknowledge to the producer |
| out_req | output | 1 | Request to the consumer |
| out_ack | input | 1 | Consumer acknowledge |
| out_data | output | WIDTH | Latch output |
| latch_en | output | 1 | Latch control: 1 holds the data, 0 passes it through |

## Verification
The bench builds two 8-bit stages side by side, one with `MODE`=0 and one with `MODE`=1, and drives each with its own producer and consumer. Thirty-two words per stage cover every pairing of producer lead-in delay and consumer response delay from 0 to 3 cycles, each pairing twice. Across that sweep, the stage meets every interleaving of `in_req` falling against `out_ack` rising that those delays allow. In particular, the sweep reaches the case where the producer still holds `in_req` high while the consumer has already acknowledged, which is where the two modes differ.

// File: rtl/pl_stage_pkg.sv
package pl_stage_pkg;

  typedef enum logic {
    CTL_COUPLED = 1'b0,
    CTL_SEMI    = 1'b1
  } ctl_mode_e;

  typedef struct packed {
    logic lt;       // latch closed
    logic in_ack;   // input channel acknowledge
    logic out_req;  // output channel request
    logic taken;    // consumer has acknowledged the held word
  } semi_state_t;

endpackage

// File: rtl/pl_rst_sync.sv
module pl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] sync_q;
  logic [LAST:0] sync_d;

  always_comb begin
    sync_d = {sync_q[LAST-1:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n = sync_q[LAST];

endmodule

// File: rtl/pl_data_latch.sv
module pl_data_latch #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lt,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] held_q;
  logic [WIDTH-1:0] held_d;
  logic             load_en;

  // The register follows the input while the latch is open.
  assign load_en = ~lt;

  always_comb begin
    held_d = held_q;
    if (load_en) held_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= held_d;
  end

  assign q = lt ? held_q : d;

  assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lt && $past(lt)) |-> (q == $past(q)));

endmodule

// File: rtl/pl_ctl_seq.sv
module pl_ctl_seq
  import pl_stage_pkg::*;
#(
  parameter ctl_mode_e MODE = CTL_SEMI
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_req,
  input  logic out_ack,
  output logic lt,
  output logic in_ack,
  output logic out_req
);

  generate
    if (MODE == CTL_COUPLED) begin : g_coupled
      logic c_q;
      logic c_d;

      // C-element of in_req and the inverse of out_ack.
      always_comb begin
        c_d = c_q;
        if (in_req && !out_ack)      c_d = 1'b1;
        else if (!in_req && out_ack) c_d = 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= 1'b0;
        else        c_q <= c_d;
      end

      assign lt      = c_q;
      assign in_ack  = c_q;
      assign out_req = c_q;

      assert_c_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_req && !out_ack) |=> out_req);
      assert_c_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_req && out_ack) |=> !out_req);

    end else begin : g_semi
      semi_state_t st_q;
      semi_state_t st_d;

      always_comb begin
        st_d = st_q;
        // Close the latch on a new word once the output side is idle.
        if (!st_q.lt && !st_q.taken && in_req && !st_q.in_ack &&
            !st_q.out_req && !out_ack)
          st_d.lt = 1'b1;
        // Reopen as soon as the consumer has the word.
        if (st_q.lt && st_q.taken)
          st_d.lt = 1'b0;
        // Release the producer only after the latch is closed.
        if (st_q.lt && in_req && !st_q.in_ack)
          st_d.in_ack = 1'b1;
        if (st_q.in_ack && !in_req && st_q.taken)
          st_d.in_ack = 1'b0;
        // Offer the held word downstream.
        if (st_q.lt && !st_q.taken && !st_q.out_req && !out_ack)
          st_d.out_req = 1'b1;
        if (st_q.out_req && out_ack) begin
          st_d.out_req = 1'b0;
          st_d.taken   = 1'b1;
        end
        if (st_q.taken && !st_q.lt && !st_q.in_ack)
          st_d.taken = 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
      end

      assign lt      = st_q.lt;
      assign in_ack  = st_q.in_ack;
      assign out_req = st_q.out_req;

      assert_close_before_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ack) |-> $past(lt));
      assert_early_reopen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_req && out_ack) |-> ##2 !lt);
      assert_ack_waits_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_ack) |-> $past(st_q.taken));
    end
  endgenerate

  assert_ack_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ack) |-> $past(in_req));
  assert_ack_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ack) |-> !$past(in_req));
  assert_req_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_req) |-> !$past(out_ack));
  assert_req_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_req) |-> $past(out_ack));
  assert_ack_needs_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ack) |-> lt);

endmodule

// File: rtl/pl_stage.sv
module pl_stage
  import pl_stage_pkg::*;
#(
  parameter int        WIDTH = 8,
  parameter ctl_mode_e MODE  = CTL_SEMI
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_req,
  input  logic [WIDTH-1:0] in_data,
  output logic             in_ack,
  output logic             out_req,
  input  logic             out_ack,
  output logic [WIDTH-1:0] out_data,
  output logic             latch_en
);

  localparam int RST_STAGES = 2;

  logic srst_n;
  logic lt;

  pl_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_n  (srst_n)
  );

  pl_ctl_seq #(.MODE(MODE)) u_ctl (
    .clk     (clk),
    .rst_n   (srst_n),
    .in_req  (in_req),
    .out_ack (out_ack),
    .lt      (lt),
    .in_ack  (in_ack),
    .out_req (out_req)
  );

  pl_data_latch #(.WIDTH(WIDTH)) u_latch (
    .clk   (clk),
    .rst_n (srst_n),
    .lt    (lt),
    .d     (in_data),
    .q     (out_data)
  );

  assign latch_en = lt;

  assert_offer_held_R5: assert property (@(posedge clk) disable iff (!srst_n)
    out_req |-> latch_en);

endmodule

// File: tb/pl_stage_env.sv
`timescale 1ns/1ps
module pl_stage_env
  import pl_stage_pkg::*;
#(
  parameter ctl_mode_e MODE   = CTL_SEMI,
  parameter int        WIDTH  = 8,
  parameter int        NWORDS = 32
) (
  input logic clk,
  input logic rst_n
);

  logic             in_req;
  logic [WIDTH-1:0] in_data;
  logic             in_ack;
  logic             out_req;
  logic             out_ack;
  logic [WIDTH-1:0] out_data;
  logic             latch_en;

  int n_chk;
  int n_bad;
  bit done;
  bit running;
  int received;

  // inputs as seen by the most recent rising edge
  logic ap_req, ap_oack, ap_oack_rise;
  logic prev_ack, prev_oreq, prev_lt;
  bit   taken;

  pl_stage #(.WIDTH(WIDTH), .MODE(MODE)) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_req   (in_req),
    .in_data  (in_data),
    .in_ack   (in_ack),
    .out_req  (out_req),
    .out_ack  (out_ack),
    .out_data (out_data),
    .latch_en (latch_en)
  );

  function automatic logic [WIDTH-1:0] word_of(int i);
    return WIDTH'(i * 75 + 29);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s mode=%0d t=%0t actual=%0h expected=%0h",
               tag, int'(MODE), $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    ap_oack_rise = out_ack && !ap_oack;
    ap_req       = in_req;
    ap_oack      = out_ack;
  end

  // Protocol monitor: outputs are registered and stable at the falling edge.
  always @(negedge clk) begin
    if (running) begin
      if (ap_oack_rise) taken = 1'b1;
      if (in_ack && !prev_ack) begin
        chk(ap_req == 1'b1, "R4 ack rise needs req", 32'(ap_req), 1);
        chk(latch_en == 1'b1, "R3 ack rise with latch closed", 32'(latch_en), 1);
        if (MODE == CTL_SEMI)
          chk(prev_lt == 1'b1, "R3 latch closed a cycle before ack", 32'(prev_lt), 1);
      end
      if (!in_ack && prev_ack) begin
        chk(ap_req == 1'b0, "R4 ack fall needs req low", 32'(ap_req), 0);
        chk(taken, "R8 ack fall before consumer ack", 32'(taken), 1);
        taken = 1'b0;
      end
      if (out_req && !prev_oreq)
        chk(ap_oack == 1'b0, "R5 req rise needs ack low", 32'(ap_oack), 0);
      if (!out_req && prev_oreq)
        chk(ap_oack == 1'b1, "R5 req fall needs ack high", 32'(ap_oack), 1);
      if (out_req)
        chk(latch_en == 1'b1, "R5 offered word held", 32'(latch_en), 1);
      if (MODE == CTL_COUPLED) begin
        logic exp_c;
        exp_c = (ap_req && !ap_oack) ? 1'b1 : ((!ap_req && ap_oack) ? 1'b0 : prev_oreq);
        chk(out_req == exp_c, "R6 C-element", 32'(out_req), 32'(exp_c));
        chk(in_ack == latch_en && latch_en == out_req, "R6 coupled equality",
            {29'd0, in_ack, latch_en, out_req}, in_ack ? 32'd7 : 32'd0);
      end
    end
    prev_ack  = in_ack;
    prev_oreq = out_req;
    prev_lt   = latch_en;
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 0; running = 0; received = 0;
    ap_req = 0; ap_oack = 0; ap_oack_rise = 0;
    prev_ack = 0; prev_oreq = 0; prev_lt = 0; taken = 0;
    in_req = 0; out_ack = 0; in_data = '0;
    @(negedge clk); @(negedge clk);
    chk({in_ack, out_req, latch_en} == 3'b000, "R1 outputs in reset",
        32'({in_ack, out_req, latch_en}), 0);
    wait (rst_n === 1'b1);
    repeat (4) @(negedge clk);
    chk({in_ack, out_req, latch_en} == 3'b000, "R1 outputs after reset",
        32'({in_ack, out_req, latch_en}), 0);
    for (int v = 0; v < 4; v++) begin
      in_data = WIDTH'(v * 97 + 3);
      #1;
      chk(out_data == in_data, "R2 transparent latch", 32'(out_data), 32'(in_data));
      @(negedge clk);
    end
    prev_ack = in_ack; prev_oreq = out_req; prev_lt = latch_en;
    running = 1;
    fork
      begin : producer
        for (int i = 0; i < NWORDS; i++) begin
          repeat (i % 4) @(negedge clk);
          in_data = word_of(i);
          in_req  = 1'b1;
          do @(negedge clk); while (!in_ack);
          repeat ((i / 2) % 3) @(negedge clk);
          in_req  = 1'b0;
          in_data = ~word_of(i);
          do @(negedge clk); while (in_ack);
        end
      end
      begin : consumer
        for (int j = 0; j < NWORDS; j++) begin
          int k;
          do @(negedge clk); while (!out_req);
          chk(out_data == word_of(j), "R9 word order", 32'(out_data), 32'(word_of(j)));
          for (int w = 0; w < (j / 4) % 4; w++) begin
            @(negedge clk);
            chk(out_data == word_of(j), "R2 held while offered", 32'(out_data),
                32'(word_of(j)));
          end
          out_ack = 1'b1;
          received++;
          k = 0;
          while (k < 2 || out_req) begin
            @(negedge clk);
            k++;
            if (MODE == CTL_SEMI && k == 2)
              chk(latch_en == 1'b0, "R7 early reopen", 32'(latch_en), 0);
          end
          out_ack = 1'b0;
        end
      end
    join
    repeat (4) @(negedge clk);
    chk(received == NWORDS, "R9 word count", 32'(received), 32'(NWORDS));
    chk({in_ack, out_req, latch_en} == 3'b000, "R1 idle after run",
        32'({in_ack, out_req, latch_en}), 0);
    running = 0;
    done = 1;
  end

endmodule

// File: tb/pl_stage_test.sv
`timescale 1ns/1ps
module pl_stage_test;
  import pl_stage_pkg::*;

  localparam int WIDTH    = 8;
  localparam int NWORDS   = 32;
  localparam int WATCHDOG = 20000;

  logic clk;
  logic rst_n;
  int   cyc;
  int   total_chk;
  int   total_bad;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  pl_stage_env #(.MODE(CTL_COUPLED), .WIDTH(WIDTH), .NWORDS(NWORDS)) env_c (
    .clk   (clk),
    .rst_n (rst_n)
  );

  pl_stage_env #(.MODE(CTL_SEMI), .WIDTH(WIDTH), .NWORDS(NWORDS)) env_s (
    .clk   (clk),
    .rst_n (rst_n)
  );

  initial begin
    rst_n = 1'b0;
    cyc   = 0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    while (!(env_c.done && env_s.done) && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    total_chk = env_c.n_chk + env_s.n_chk;
    total_bad = env_c.n_bad + env_s.n_bad;
    if (cyc >= WATCHDOG) begin
      total_chk++;
      total_bad++;
      $display("FAIL R9 watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG);
    end
    $display("== %0d vectors applied, %0d miscompares ==", total_chk, total_bad);
    $finish;
  end

endmodule